// File: doc/BRIEF.md
# Receive Descriptor Ring DMA

This block takes an incoming Ethernet frame as a byte stream and stores it into receive buffers in system memory. A ring of 8-byte descriptors in that memory names the buffers. Word 0 of a descriptor at address D holds the flags in bits 31:16 and the length in bits 15:0. Word 1, at D+4, holds the buffer address. Software arms a descriptor by setting its empty flag (0x8000), programs the ring start and then rings a doorbell. The engine then owns the empty descriptors, in ring order.

Each frame is split across as many buffers as it needs. No buffer takes more than the programmed maximum buffer size. A 4-byte CRC follows the frame data. Each filled descriptor is written back with its empty flag cleared and the number of bytes stored. The last descriptor of a frame also carries the last flag and the error flags. One-cycle pulses mark each buffer handed back.

Receive-active status follows the empty flag of the current descriptor. It is checked on the doorbell and again after every frame. Input bytes are only taken while it is set.

Top module: `rx_ring_dma`

## Requirements
- R1: Host registers are selected by `reg_addr`. Address 0 is enable (bit 0, reset 0). Address 1 is the doorbell: a write rings it, and a read returns the active status in bit 24 and zero elsewhere. Address 2 is receive control: it keeps mask 0x07FF003F, resets to 0x05EE0000, and bits 31:16 are the length limit. Address 3 is the ring start: it clears bits 1:0 and resets to 0. Address 4 is the maximum buffer size: it keeps mask 0x7F0 and resets to 0x600.
- R2: A doorbell written while enabled and inactive reads the current descriptor. Receive becomes active only if that descriptor's empty flag 0x8000 is set. A doorbell written while disabled has no effect.
- R3: `in_ready` is low whenever receive is inactive. The only exception is while the rest of a dropped frame is being discarded (R10).
- R4: Data bytes are written one at a time, with `mem_byte`=1 and the byte in `mem_wdata[7:0]`, to buffer address + offset. A buffer holds at most the maximum buffer size, and a value of 0 is taken as 16. The length field written back equals the bytes stored in that buffer.
- R5: After the data comes the frame check sequence: CRC-32, reflected polynomial 0xEDB88320, preset all ones, result inverted. It is stored most significant byte first and is counted in the stored length.
- R6: Write-back is word 0 only, with flags 0x8000 cleared and the other flags kept. The final buffer also gets 0x0800 and the error flags, and pulses `ev_rxf`. Each earlier buffer pulses `ev_rxb`.
- R7: A frame whose data plus CRC would exceed 2032 bytes keeps only its first 2028 data bytes. The CRC, computed over all input bytes, is still appended. Flags 0x0001 and 0x0020 are set.
- R8: A frame whose stored length exceeds the receive-control limit gets flag 0x0020, and all of its bytes are still stored.
- R9: The next descriptor is the ring start if the wrap flag 0x2000 is set, otherwise the current address + 8. After each frame, the next descriptor's empty flag decides whether receive stays active.
- R10: If a descriptor met in the middle of a frame is not empty, it is left unchanged. The remaining input bytes of that frame are accepted and discarded, no `ev_rxf` is raised, and receive becomes inactive.
- R11: Clearing enable while active and between frames makes receive inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register select |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data (combinational) |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of frame |
| in_ready | output | 1 | Byte accepted when high with `in_valid` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write |
| mem_byte | output | 1 | Byte write (else aligned 32-bit word) |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| ev_rxf | output | 1 | Frame-complete pulse |
| ev_rxb | output | 1 | Intermediate-buffer pulse |

## Verification
The assertions take two things for granted about the memory port: `mem_ack` comes only while `mem_req` is high, and never twice in a row for one request. The bench memory model acknowledges one cycle after it first sees a request and then stays low for a cycle. The assertions also assume that the ring start and maximum buffer size are not rewritten while a frame is being stored. The bench rewrites them only after a frame has fully drained and receive is idle or inactive.

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int AW        = 32,
  parameter int MAX_FRAME = 2032
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  output logic          in_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_byte,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          ev_rxf,
  output logic          ev_rxb
);
  localparam int CW = $clog2(MAX_FRAME + 1);
  localparam logic [CW-1:0] DATA_MAX = CW'(MAX_FRAME - 4);
  localparam logic [15:0] F_E = 16'h8000, F_W = 16'h2000, F_L = 16'h0800;
  localparam logic [15:0] F_LG = 16'h0020, F_TR = 16'h0001;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_WAIT, S_PUT, S_WR, S_CLOSE, S_FIN, S_DROP
  } st_t;

  st_t            state;
  logic           enable, rx_active;
  logic [31:0]    rxctl;
  logic [AW-1:0]  ring, cur, bptr;
  logic [10:0]    bufmax, cnt, eff_max;
  logic [15:0]    flags, errf, clr_flags;
  logic [CW-1:0]  stored;
  logic [7:0]     pend, crc_byte;
  logic [31:0]    crc, fcs_sh;
  logic [1:0]     crc_idx;
  logic           infr, data_done, in_crc, trunc;
  logic           take, db_hit;
  logic [AW-1:0]  next_desc;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'b0, d};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  assign eff_max   = (bufmax == 11'd0) ? 11'd16 : bufmax;
  assign fcs_sh    = ~crc >> {2'd3 - crc_idx, 3'b000};
  assign crc_byte  = fcs_sh[7:0];
  assign errf      = (trunc ? (F_TR | F_LG) : 16'h0) |
                     ((32'(stored) > 32'(rxctl[31:16])) ? F_LG : 16'h0);
  assign clr_flags = flags & ~F_E;
  assign next_desc = ((flags & F_W) != 16'h0) ? ring : cur + AW'(8);
  assign db_hit    = reg_wr && reg_addr == 3'd1;

  assign in_ready = (state == S_WAIT && (enable || infr)) || state == S_DROP;
  assign take     = in_valid && in_ready;

  assign mem_req  = state inside {S_RD0, S_RD1, S_WR, S_CLOSE, S_FIN};
  assign mem_we   = state inside {S_WR, S_CLOSE, S_FIN};
  assign mem_byte = state == S_WR;

  always_comb begin
    case (state)
      S_RD1:   mem_addr = cur + AW'(4);
      S_WR:    mem_addr = bptr + AW'(cnt);
      default: mem_addr = cur;
    endcase
    case (state)
      S_WR:    mem_wdata = {24'b0, pend};
      S_CLOSE: mem_wdata = {clr_flags, 5'b0, cnt};
      S_FIN:   mem_wdata = {clr_flags | F_L | errf, 5'b0, cnt};
      default: mem_wdata = 32'b0;
    endcase
    case (reg_addr)
      3'd0:    reg_rdata = {31'b0, enable};
      3'd1:    reg_rdata = {7'b0, rx_active, 24'b0};
      3'd2:    reg_rdata = rxctl;
      3'd3:    reg_rdata = 32'(ring);
      3'd4:    reg_rdata = {21'b0, bufmax};
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  enable <= 1'b0;  rx_active <= 1'b0;
      rxctl <= 32'h05EE_0000;  bufmax <= 11'h600;
      ring <= '0;  cur <= '0;  bptr <= '0;  flags <= '0;
      cnt <= '0;  stored <= '0;  pend <= '0;  crc <= '1;  crc_idx <= '0;
      infr <= 1'b0;  data_done <= 1'b0;  in_crc <= 1'b0;  trunc <= 1'b0;
      ev_rxf <= 1'b0;  ev_rxb <= 1'b0;
    end else begin
      ev_rxf <= 1'b0;
      ev_rxb <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: enable <= reg_wdata[0];
          3'd2: rxctl  <= reg_wdata & 32'h07FF_003F;
          3'd3: begin
            ring <= reg_wdata[AW-1:0] & ~AW'(3);
            if (state == S_IDLE) cur <= reg_wdata[AW-1:0] & ~AW'(3);
          end
          3'd4: bufmax <= reg_wdata[10:0] & 11'h7F0;
          default: ;
        endcase
      end
      case (state)
        S_IDLE: if (db_hit && enable && !rx_active) state <= S_RD0;
        S_RD0: if (mem_ack) begin
          flags <= mem_rdata[31:16];
          if (mem_rdata[31]) state <= S_RD1;
          else begin
            rx_active <= 1'b0;
            state <= (infr && !data_done) ? S_DROP : S_IDLE;
            infr <= 1'b0;  data_done <= 1'b0;  in_crc <= 1'b0;  trunc <= 1'b0;
            stored <= '0;  crc <= '1;
          end
        end
        S_RD1: if (mem_ack) begin
          bptr <= mem_rdata[AW-1:0];
          cnt  <= '0;
          if (infr) state <= S_WR;
          else begin
            rx_active <= 1'b1;
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (!enable && !infr) begin
            rx_active <= 1'b0;
            state <= S_IDLE;
          end else if (take) begin
            infr <= 1'b1;
            crc  <= crc_step(crc, in_data);
            if (in_last) data_done <= 1'b1;
            if (stored >= DATA_MAX) begin
              trunc <= 1'b1;
              if (in_last) begin
                in_crc <= 1'b1;  crc_idx <= '0;  state <= S_PUT;
              end
            end else begin
              pend  <= in_data;
              state <= S_PUT;
            end
          end
        end
        S_PUT: begin
          if (in_crc) pend <= crc_byte;
          state <= (cnt == eff_max) ? S_CLOSE : S_WR;
        end
        S_WR: if (mem_ack) begin
          cnt    <= cnt + 11'd1;
          stored <= stored + CW'(1);
          if (in_crc) begin
            if (crc_idx == 2'd3) state <= S_FIN;
            else begin
              crc_idx <= crc_idx + 2'd1;  state <= S_PUT;
            end
          end else if (data_done) begin
            in_crc <= 1'b1;  crc_idx <= '0;  state <= S_PUT;
          end else state <= S_WAIT;
        end
        S_CLOSE: if (mem_ack) begin
          ev_rxb <= 1'b1;
          cur    <= next_desc;
          state  <= S_RD0;
        end
        S_FIN: if (mem_ack) begin
          ev_rxf <= 1'b1;
          cur    <= next_desc;
          infr <= 1'b0;  data_done <= 1'b0;  in_crc <= 1'b0;  trunc <= 1'b0;
          stored <= '0;  crc <= '1;
          state  <= S_RD0;
        end
        S_DROP: if (take && in_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r4_buf_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_byte) |-> (cnt < eff_max));
  a_r4_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r6_wb_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_byte) |-> !mem_wdata[31]);
  a_r6_events_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_rxf && ev_rxb));
  a_r7_frame_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(stored) <= 32'(MAX_FRAME));
  a_r2_active_from_desc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(state == S_RD1 && mem_ack));
  a_r3_ready_active: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && state != S_DROP) |-> rx_active);
endmodule

// File: tb/rx_ring_dma_test.sv
module rx_ring_dma_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0]  in_data = '0;
  logic        mem_req, mem_we, mem_byte, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        ev_rxf, ev_rxb;

  rx_ring_dma uut (.*);

  logic [7:0] mem [0:8191];
  logic [7:0] fr  [0:2199];
  int n_chk = 0, n_fail = 0, n_rxf = 0, n_rxb = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      if (mem_we && mem_byte) mem[mem_addr[12:0]] = mem_wdata[7:0];
      else if (mem_we) begin
        mem[{mem_addr[12:2], 2'd0}] = mem_wdata[31:24];
        mem[{mem_addr[12:2], 2'd1}] = mem_wdata[23:16];
        mem[{mem_addr[12:2], 2'd2}] = mem_wdata[15:8];
        mem[{mem_addr[12:2], 2'd3}] = mem_wdata[7:0];
      end else
        mem_rdata <= {mem[{mem_addr[12:2], 2'd0}], mem[{mem_addr[12:2], 2'd1}],
                      mem[{mem_addr[12:2], 2'd2}], mem[{mem_addr[12:2], 2'd3}]};
      mem_ack <= 1'b1;
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    if (rst_n && ev_rxf) n_rxf++;
    if (rst_n && ev_rxb) n_rxb++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] rd_w0(int a);
    return {mem[a], mem[a+1], mem[a+2], mem[a+3]};
  endfunction

  task automatic set_desc(int a, logic [31:0] w0, logic [31:0] ptr);
    {mem[a], mem[a+1], mem[a+2], mem[a+3]} = w0;
    {mem[a+4], mem[a+5], mem[a+6], mem[a+7]} = ptr;
  endtask

  function automatic logic [31:0] fcs(int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'b0, fr[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic send(int n, int seed);
    for (int i = 0; i < n; i++) fr[i] = 8'((seed + i * 13) & 8'hFF);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fr[i]; in_last = (i == n - 1);
      do @(posedge clk); while (!in_ready);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic chk_bytes(string tag, int a, int first, int n);
    int bad = 0;
    for (int k = 0; k < n; k++) if (mem[a+k] !== fr[first+k]) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd_reg(3'd0, d); chk("R1 enable reset", d, 32'h0);
    rd_reg(3'd1, d); chk("R1 doorbell reset", d, 32'h0);
    rd_reg(3'd2, d); chk("R1 rxctl reset", d, 32'h05EE_0000);
    rd_reg(3'd3, d); chk("R1 ring reset", d, 32'h0);
    rd_reg(3'd4, d); chk("R1 bufmax reset", d, 32'h600);
    chk("R3 ready at reset", 32'(in_ready), 0);
  endtask

  task automatic t_masks;
    logic [31:0] d;
    wr_reg(3'd2, 32'hFFFF_FFFF); rd_reg(3'd2, d); chk("R1 rxctl mask", d, 32'h07FF_003F);
    wr_reg(3'd3, 32'h0000_0107); rd_reg(3'd3, d); chk("R1 ring mask", d, 32'h104);
    wr_reg(3'd4, 32'h0000_FFFF); rd_reg(3'd4, d); chk("R1 bufmax mask", d, 32'h7F0);
    wr_reg(3'd2, 32'h05EE_0000);
  endtask

  task automatic t_doorbell;
    logic [31:0] d;
    set_desc(32'h00, 32'h8000_0000, 32'h100);
    set_desc(32'h08, 32'h8000_0000, 32'h200);
    set_desc(32'h10, 32'hA000_0000, 32'h300);
    wr_reg(3'd3, 32'h0); wr_reg(3'd4, 32'h40);
    wr_reg(3'd1, 32'h0);
    repeat (10) @(negedge clk);
    rd_reg(3'd1, d); chk("R2 doorbell while disabled", d, 32'h0);
    wr_reg(3'd0, 32'h1); wr_reg(3'd1, 32'h0);
    repeat (10) @(negedge clk);
    rd_reg(3'd1, d); chk("R2 active after doorbell", d, 32'h0100_0000);
    chk("R3 ready when active", 32'(in_ready), 1);
  endtask

  task automatic t_single;
    logic [31:0] f;
    int r0 = n_rxf, b0 = n_rxb;
    send(20, 5);
    f = fcs(20);
    chk("R6 single wb", rd_w0(32'h00), 32'h0800_0018);
    chk_bytes("R4 single data", 32'h100, 0, 20);
    chk("R5 single crc", rd_w0(32'h114), f);
    chk("R6 single rxf", n_rxf - r0, 1);
    chk("R6 single rxb", n_rxb - b0, 0);
  endtask

  task automatic t_scatter;
    logic [31:0] f, d;
    int r0 = n_rxf, b0 = n_rxb;
    set_desc(32'h00, 32'h8000_0000, 32'h400);
    wr_reg(3'd4, 32'h10);
    send(30, 77);
    f = fcs(30);
    chk("R4 scatter wb1", rd_w0(32'h08), 32'h0000_0010);
    chk("R9 scatter wb2 keeps wrap", rd_w0(32'h10), 32'h2000_0010);
    chk("R9 scatter wrap wb3", rd_w0(32'h00), 32'h0800_0002);
    chk_bytes("R4 scatter buf1", 32'h200, 0, 16);
    chk_bytes("R4 scatter buf2", 32'h300, 16, 14);
    chk("R5 scatter crc split", {mem[32'h30E], mem[32'h30F], mem[32'h400], mem[32'h401]}, f);
    chk("R6 scatter rxb", n_rxb - b0, 2);
    chk("R6 scatter rxf", n_rxf - r0, 1);
    rd_reg(3'd1, d); chk("R9 inactive at used desc", d, 32'h0);
    chk("R3 ready when inactive", 32'(in_ready), 0);
  endtask

  task automatic t_limit;
    set_desc(32'h40, 32'h8000_0000, 32'h500);
    set_desc(32'h48, 32'hA000_0000, 32'h600);
    wr_reg(3'd3, 32'h40); wr_reg(3'd4, 32'h40); wr_reg(3'd2, 32'h0014_0000);
    wr_reg(3'd1, 32'h0);
    repeat (10) @(negedge clk);
    send(30, 200);
    chk("R8 limit wb", rd_w0(32'h40), 32'h0820_0022);
    chk_bytes("R8 limit stored", 32'h500, 0, 30);
    chk("R8 limit crc", rd_w0(32'h51E), fcs(30));
    wr_reg(3'd2, 32'h05EE_0000);
  endtask

  task automatic t_trunc;
    logic [31:0] d;
    wr_reg(3'd4, 32'h7F0);
    send(2100, 3);
    chk("R7 trunc wb", rd_w0(32'h48), 32'h2821_07F0);
    chk_bytes("R7 trunc data", 32'h600, 0, 2028);
    chk("R7 trunc crc", rd_w0(32'h600 + 2028), fcs(2100));
    rd_reg(3'd1, d); chk("R9 wrapped to used desc", d, 32'h0);
  endtask

  task automatic t_midframe;
    logic [31:0] d;
    int r0 = n_rxf, b0 = n_rxb;
    set_desc(32'h80, 32'h8000_0000, 32'h1000);
    set_desc(32'h88, 32'h0000_1234, 32'h1100);
    wr_reg(3'd3, 32'h80); wr_reg(3'd4, 32'h10);
    wr_reg(3'd1, 32'h0);
    repeat (10) @(negedge clk);
    send(30, 9);
    chk("R10 first buffer closed", rd_w0(32'h80), 32'h0000_0010);
    chk_bytes("R10 first buffer data", 32'h1000, 0, 16);
    chk("R10 busy desc untouched", rd_w0(32'h88), 32'h0000_1234);
    chk("R10 no rxf", n_rxf - r0, 0);
    chk("R10 one rxb", n_rxb - b0, 1);
    rd_reg(3'd1, d); chk("R10 inactive", d, 32'h0);
    chk("R3 ready after drop", 32'(in_ready), 0);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    set_desc(32'hC0, 32'h8000_0000, 32'h1200);
    wr_reg(3'd3, 32'hC0);
    wr_reg(3'd1, 32'h0);
    repeat (10) @(negedge clk);
    rd_reg(3'd1, d); chk("R11 active before disable", d, 32'h0100_0000);
    wr_reg(3'd0, 32'h0);
    repeat (4) @(negedge clk);
    rd_reg(3'd1, d); chk("R11 inactive after disable", d, 32'h0);
    chk("R11 ready low", 32'(in_ready), 0);
    wr_reg(3'd1, 32'h0);
    repeat (10) @(negedge clk);
    rd_reg(3'd1, d); chk("R2 disabled doorbell ignored", d, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_masks;
    t_doorbell;
    t_single;
    t_scatter;
    t_limit;
    t_trunc;
    t_midframe;
    t_disable;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule